// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block forms the memory address for one load or store and the value that a base register would take if it is updated. It has three indexing modes. They differ in two ways: which value goes to memory, and whether the base is written back. The offset can come from three sources: a zero-extended immediate, an index register, or an index register shifted left by a 5-bit amount. One flag picks whether that offset magnitude is added to or subtracted from the base. All sums wrap modulo 2^32.

The arithmetic is combinational. By default a single register stage sits between the arithmetic and the outputs (`OUT_REG = 1`), so results appear one clock after their inputs are sampled. With `OUT_REG = 0` the outputs follow the inputs directly. A control module decodes the mode and operand selects into a small set of strobes. A datapath module uses those strobes to pick the operand, shift it, add or subtract it, and steer the results.

Top module: `ldst_agu`

## Requirements
- R1: Mode 2'b00 (offset): accAddr = base ± offset, wbVal carries the same sum, and wbEn is 0.
- R2: Mode 2'b01 (pre-indexed): accAddr = base ± offset, wbVal equals accAddr, and wbEn is 1.
- R3: Mode 2'b10 (post-indexed): accAddr equals the unmodified base, wbVal = base ± offset, and wbEn is 1.
- R4: Operand select 2'b00 uses the 12-bit immediate, zero-extended to 32 bits, as the offset magnitude.
- R5: Operand select 2'b01 uses the 32-bit index value unchanged as the offset magnitude.
- R6: Operand select 2'b10 or 2'b11 uses the index value shifted left by the shift amount (0 to 31). A shift of 0 passes the index through, and bits shifted out past bit 31 are lost.
- R7: subtract = 1 subtracts the offset magnitude from the base and subtract = 0 adds it, for every operand select. For example, base 0x1000 minus 0x10 gives 0x0FF0.
- R8: All sums and differences wrap modulo 2^32 and produce no overflow indication.
- R9: Mode 2'b11 is reserved and behaves exactly like offset mode, with wbEn 0.
- R10: With OUT_REG = 1, the outputs reflect the inputs sampled at the previous rising clock edge. While rstN is low, accAddr, wbVal and wbEn are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| baseVal | input | 32 | Base register value |
| immOff | input | 12 | Immediate offset magnitude |
| idxVal | input | 32 | Index register value |
| shAmt | input | 5 | Left shift amount for the shifted-register operand |
| subtract | input | 1 | 1 = subtract the offset, 0 = add it |
| opSel | input | 2 | Offset source: 00 immediate, 01 register, 1x shifted register |
| modeSel | input | 2 | 00 offset, 01 pre-indexed, 10 post-indexed, 11 reserved (offset) |
| accAddr | output | 32 | Address sent to memory |
| wbVal | output | 32 | Value for base register writeback |
| wbEn | output | 1 | Writeback enable |

## Verification
The assertions assume that every input is driven to a known value in each cycle and does not change between the clock edges that sample it. They also assume that reset is held through at least one rising edge before any outputs are checked. The bench drives all inputs on the falling clock edge, so each rising edge captures a settled, fully defined vector. It keeps rstN low for several edges at the start. Shift amounts and data cover the full range, including the extremes 0 and 31 and vectors that wrap past 2^32 in both directions, so none of these are excluded by an assumption.

// File: rtl/ldst_agu_pkg.sv
package ldst_agu_pkg;

  typedef enum logic [1:0] {
    MODE_OFFSET = 2'b00,
    MODE_PRE    = 2'b01,
    MODE_POST   = 2'b10,
    MODE_RSVD   = 2'b11
  } idxMode_e;

  typedef enum logic [1:0] {
    SRC_IMM   = 2'b00,
    SRC_REG   = 2'b01,
    SRC_SHREG = 2'b10,
    SRC_SHALT = 2'b11
  } offSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic useImm;
    logic useShift;
    logic doSub;
    logic addrFromBase;
    logic wbEnable;
  } aguCtrl_t;

endpackage

// File: rtl/ldst_agu_ctrl.sv
module ldst_agu_ctrl
  import ldst_agu_pkg::*;
(
  input  logic [1:0] modeSel,
  input  logic [1:0] opSel,
  input  logic       subtract,
  output aguCtrl_t   ctrl
);

  idxMode_e modeDec;
  offSrc_e  srcDec;

  always_comb begin
    modeDec = idxMode_e'(modeSel);
    srcDec  = offSrc_e'(opSel);

    ctrl = '0;
    ctrl.doSub = subtract;

    unique case (srcDec)
      SRC_IMM:   ctrl.useImm = 1'b1;
      SRC_REG:   ctrl.useShift = 1'b0;
      SRC_SHREG,
      SRC_SHALT: ctrl.useShift = 1'b1;
      default:   ctrl.useImm = 1'b1;
    endcase

    unique case (modeDec)
      MODE_PRE: begin
        ctrl.addrFromBase = 1'b0;
        ctrl.wbEnable     = 1'b1;
      end
      MODE_POST: begin
        ctrl.addrFromBase = 1'b1;
        ctrl.wbEnable     = 1'b1;
      end
      MODE_OFFSET,
      MODE_RSVD: begin
        ctrl.addrFromBase = 1'b0;
        ctrl.wbEnable     = 1'b0;
      end
      default: begin
        ctrl.addrFromBase = 1'b0;
        ctrl.wbEnable     = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ldst_agu_datapath.sv
module ldst_agu_datapath
  import ldst_agu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 12,
  parameter int SHAMT_W = 5
) (
  input  logic [DATA_W-1:0]  baseVal,
  input  logic [IMM_W-1:0]   immOff,
  input  logic [DATA_W-1:0]  idxVal,
  input  logic [SHAMT_W-1:0] shAmt,
  input  aguCtrl_t           ctrl,
  output logic [DATA_W-1:0]  addrOut,
  output logic [DATA_W-1:0]  wbOut,
  output logic               wbEnOut
);

  localparam int PAD_W = DATA_W - IMM_W;

  // logarithmic left shifter, one stage per shift-amount bit
  logic [DATA_W-1:0] shStage [SHAMT_W+1];

  assign shStage[0] = idxVal;

  for (genvar s = 0; s < SHAMT_W; s++) begin : g_shift
    localparam int STEP = 1 << s;
    if (STEP < DATA_W) begin : g_part
      assign shStage[s+1] = shAmt[s] ?
        {shStage[s][DATA_W-STEP-1:0], {STEP{1'b0}}} : shStage[s];
    end else begin : g_full
      assign shStage[s+1] = shAmt[s] ? '0 : shStage[s];
    end
  end

  logic [DATA_W-1:0] offMag;
  logic [DATA_W-1:0] offOperand;
  logic [DATA_W-1:0] sumVal;

  always_comb begin
    if (ctrl.useImm) begin
      offMag = {{PAD_W{1'b0}}, immOff};
    end else if (ctrl.useShift) begin
      offMag = shStage[SHAMT_W];
    end else begin
      offMag = idxVal;
    end
  end

  // two's complement subtract through a shared adder
  assign offOperand = ctrl.doSub ? ~offMag : offMag;
  assign sumVal     = baseVal + offOperand + {{(DATA_W-1){1'b0}}, ctrl.doSub};

  assign addrOut = ctrl.addrFromBase ? baseVal : sumVal;
  assign wbOut   = sumVal;
  assign wbEnOut = ctrl.wbEnable;

endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
  import ldst_agu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 12,
  parameter int SHAMT_W = 5,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  baseVal,
  input  logic [IMM_W-1:0]   immOff,
  input  logic [DATA_W-1:0]  idxVal,
  input  logic [SHAMT_W-1:0] shAmt,
  input  logic               subtract,
  input  logic [1:0]         opSel,
  input  logic [1:0]         modeSel,
  output logic [DATA_W-1:0]  accAddr,
  output logic [DATA_W-1:0]  wbVal,
  output logic               wbEn
);

  aguCtrl_t          ctrl;
  logic [DATA_W-1:0] addrNext;
  logic [DATA_W-1:0] wbNext;
  logic              wbEnNext;

  ldst_agu_ctrl u_ctrl (
    .modeSel  (modeSel),
    .opSel    (opSel),
    .subtract (subtract),
    .ctrl     (ctrl)
  );

  ldst_agu_datapath #(
    .DATA_W  (DATA_W),
    .IMM_W   (IMM_W),
    .SHAMT_W (SHAMT_W)
  ) u_dp (
    .baseVal (baseVal),
    .immOff  (immOff),
    .idxVal  (idxVal),
    .shAmt   (shAmt),
    .ctrl    (ctrl),
    .addrOut (addrNext),
    .wbOut   (wbNext),
    .wbEnOut (wbEnNext)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        accAddr <= '0;
        wbVal   <= '0;
        wbEn    <= 1'b0;
      end else begin
        accAddr <= addrNext;
        wbVal   <= wbNext;
        wbEn    <= wbEnNext;
      end
    end
  end else begin : g_comb
    assign accAddr = addrNext;
    assign wbVal   = wbNext;
    assign wbEn    = wbEnNext;
  end

endmodule

// File: rtl/ldst_agu_checker.sv
module ldst_agu_checker #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 12,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] baseVal,
  input logic [IMM_W-1:0]  immOff,
  input logic              subtract,
  input logic [1:0]        opSel,
  input logic [1:0]        modeSel,
  input logic [DATA_W-1:0] accAddr,
  input logic [DATA_W-1:0] wbVal,
  input logic              wbEn
);

  localparam int PAD_W = DATA_W - IMM_W;

  if (OUT_REG) begin : g_seq
    a_r1_offset_no_wb: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(modeSel) == 2'b00) |-> !wbEn);

    a_r2_pre_addr_is_wb: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(modeSel) == 2'b01) |-> (wbEn && accAddr == wbVal));

    a_r3_post_addr_is_base: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(modeSel) == 2'b10) |-> (wbEn && accAddr == $past(baseVal)));

    a_r9_reserved_no_wb: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(modeSel) == 2'b11) |-> !wbEn);

    a_r7_imm_subtract: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(opSel) == 2'b00 && $past(subtract))
        |-> (wbVal == $past(baseVal) - {{PAD_W{1'b0}}, $past(immOff)}));

    a_r10_reset_clear: assert property (@(posedge clk)
      $past(!rstN) |-> (accAddr == '0 && wbVal == '0 && !wbEn));
  end else begin : g_imm
    always_comb begin
      if (rstN) begin
        a_r1_offset_no_wb: assert (!(modeSel == 2'b00 && wbEn));
        a_r2_pre_addr_is_wb: assert (!(modeSel == 2'b01) || (wbEn && accAddr == wbVal));
        a_r3_post_addr_is_base: assert (!(modeSel == 2'b10) || (wbEn && accAddr == baseVal));
        a_r9_reserved_no_wb: assert (!(modeSel == 2'b11 && wbEn));
        a_r7_imm_subtract: assert (!(opSel == 2'b00 && subtract) ||
          wbVal == baseVal - {{PAD_W{1'b0}}, immOff});
      end
    end
  end

endmodule

bind ldst_agu ldst_agu_checker #(
  .DATA_W  (DATA_W),
  .IMM_W   (IMM_W),
  .OUT_REG (OUT_REG)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .baseVal  (baseVal),
  .immOff   (immOff),
  .subtract (subtract),
  .opSel    (opSel),
  .modeSel  (modeSel),
  .accAddr  (accAddr),
  .wbVal    (wbVal),
  .wbEn     (wbEn)
);

// File: tb/ldst_agu_test.sv
module ldst_agu_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] baseVal = '0;
  logic [11:0] immOff = '0;
  logic [31:0] idxVal = '0;
  logic [4:0]  shAmt = '0;
  logic        subtract = 1'b0;
  logic [1:0]  opSel = '0;
  logic [1:0]  modeSel = '0;
  logic [31:0] accAddr;
  logic [31:0] wbVal;
  logic        wbEn;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ldst_agu uut (
    .clk(clk), .rstN(rstN), .baseVal(baseVal), .immOff(immOff),
    .idxVal(idxVal), .shAmt(shAmt), .subtract(subtract), .opSel(opSel),
    .modeSel(modeSel), .accAddr(accAddr), .wbVal(wbVal), .wbEn(wbEn)
  );

  // behavioural reference: 64-bit integer math reduced modulo 2^32
  typedef struct { longint unsigned addr; longint unsigned wb; bit en; } exp_t;
  exp_t expQ[$];

  function automatic exp_t model(longint unsigned b, longint unsigned imm,
                                 longint unsigned idx, int sh, bit sub,
                                 int op, int mode);
    exp_t e;
    longint unsigned mag, sum;
    if (op == 0) mag = imm;
    else if (op == 1) mag = idx;
    else mag = (idx * (64'd1 << sh)) % 64'h1_0000_0000;
    if (sub) sum = (b + 64'h1_0000_0000 - mag) % 64'h1_0000_0000;
    else     sum = (b + mag) % 64'h1_0000_0000;
    e.wb = sum;
    if (mode == 2) e.addr = b; else e.addr = sum;
    e.en = (mode == 1 || mode == 2);
    return e;
  endfunction

  task automatic check(string req);
    exp_t e;
    e = expQ.pop_front();
    compared++;
    if (accAddr !== e.addr[31:0] || wbVal !== e.wb[31:0] || wbEn !== e.en) begin
      mismatched++;
      $display("FAIL %s: got addr=%h wb=%h en=%b expected addr=%h wb=%h en=%b",
               req, accAddr, wbVal, wbEn, e.addr[31:0], e.wb[31:0], e.en);
    end
  endtask

  // drive on falling edge, check on next falling edge (one register stage)
  task automatic step(input logic [31:0] b, input logic [11:0] imm,
                      input logic [31:0] idx, input logic [4:0] sh,
                      input bit sub, input logic [1:0] op,
                      input logic [1:0] mode, input string req);
    baseVal = b; immOff = imm; idxVal = idx; shAmt = sh;
    subtract = sub; opSel = op; modeSel = mode;
    expQ.push_back(model(b, imm, idx, sh, sub, op, mode));
    @(negedge clk);
    check(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    baseVal = 32'hDEAD_BEEF; modeSel = 2'b01; opSel = 2'b01; idxVal = 32'h5;
    repeat (3) @(negedge clk);
    // R10: outputs cleared while reset is low
    compared++;
    if (accAddr !== '0 || wbVal !== '0 || wbEn !== 1'b0) begin
      mismatched++;
      $display("FAIL R10: got addr=%h wb=%h en=%b expected 0 0 0", accAddr, wbVal, wbEn);
    end
    rstN = 1'b1;

    // R7 / R1: 0x1000 - 0x10 = 0x0FF0 in offset mode
    step(32'h1000, 12'h010, 32'h0, 5'd0, 1'b1, 2'b00, 2'b00, "R7 R1 R4");
    // R2 pre-indexed, immediate subtract
    step(32'h1000, 12'h010, 32'h0, 5'd0, 1'b1, 2'b00, 2'b01, "R2 R7");
    // R3 post-indexed, immediate subtract
    step(32'h1000, 12'h010, 32'h0, 5'd0, 1'b1, 2'b00, 2'b10, "R3 R7");
    // R4 full immediate zero-extended
    step(32'h0000_0001, 12'hFFF, 32'hFFFF_FFFF, 5'd3, 1'b0, 2'b00, 2'b00, "R4");
    // R5 register operand, add
    step(32'h2000_0000, 12'h123, 32'h0000_4444, 5'd7, 1'b0, 2'b01, 2'b01, "R5");
    // R6 shift 0 passes through
    step(32'h100, 12'h0, 32'h0000_00F0, 5'd0, 1'b0, 2'b10, 2'b01, "R6");
    // R6 shift 31 drops upper bits, alternate encoding 2'b11
    step(32'h0, 12'h0, 32'h0000_0003, 5'd31, 1'b0, 2'b11, 2'b10, "R6");
    // R6 shift 4 subtract
    step(32'h1000, 12'h0, 32'h0000_0001, 5'd4, 1'b1, 2'b10, 2'b00, "R6 R7");
    // R8 wrap on add and on subtract
    step(32'hFFFF_FFF0, 12'h020, 32'h0, 5'd0, 1'b0, 2'b00, 2'b01, "R8");
    step(32'h0000_0008, 12'h0, 32'h0000_0010, 5'd0, 1'b1, 2'b01, 2'b10, "R8");
    // R9 reserved mode behaves as offset
    step(32'h4000, 12'h040, 32'h0, 5'd0, 1'b0, 2'b00, 2'b11, "R9");
    step(32'h4000, 12'h0, 32'h10, 5'd2, 1'b1, 2'b10, 2'b11, "R9");

    // R10 reset in mid-run clears outputs
    rstN = 1'b0;
    @(negedge clk);
    compared++;
    if (accAddr !== '0 || wbVal !== '0 || wbEn !== 1'b0) begin
      mismatched++;
      $display("FAIL R10: got addr=%h wb=%h en=%b expected 0 0 0", accAddr, wbVal, wbEn);
    end
    rstN = 1'b1;

    // random sweep across all modes and operand sources (R1-related mix)
    for (int i = 0; i < 400; i++) begin
      step($urandom, 12'($urandom), $urandom, 5'($urandom), 1'($urandom),
           2'($urandom), 2'($urandom), "R1 R2 R3 R5 R6 R8 random");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule